// File: doc/BRIEF.md
# Wide-Issue Register File with Cycle Counter

This block is the general-purpose register storage for a very-long-instruction-word core that issues several independent operations in one instruction. Each issue slot gets two combinational read ports and one clocked write port with its own enable. Two low register numbers are wired to constants. Zero is a sink for results that are not needed. One is a handy operand. Writes to either constant register are dropped. When several slots write the same register in one cycle, the highest-numbered slot wins. A read in the cycle of a write to the same register still sees the stored value.

The block also holds a free-running cycle counter. It is cleared only by reset and advances once per clock. The counter has no overflow handling, because at the default width it does not wrap within any practical run time. Software reads it as two halves. A small two-state machine keeps the upper half coherent. In state SNAP_LIVE the upper-half output follows the counter. A low-half read strobe captures the upper half and takes the transition LIVE_TO_HELD. In state SNAP_HELD the upper-half output shows the captured value. Another low-half strobe re-captures and stays in SNAP_HELD (transition HELD_RECAPTURE). A high-half read strobe without a low strobe takes the transition HELD_TO_LIVE.

Top module: `vrf_top`

## Requirements
- R1: A write with its enable high stores the data in the addressed register (2 to NUM_REGS-1) at the clock edge. From the next cycle on, any read port that addresses that register returns the stored data.
- R2: Register 0 always reads as zero on every read port.
- R3: Register 1 always reads as the value one on every read port.
- R4: A write to register 0 or register 1 has no effect on what those registers read.
- R5: When two or more enabled slots write the same register in one cycle, the register takes the data of the slot with the highest index.
- R6: A read of a register in the same cycle as a write to it returns the value held before that write.
- R7: A write port whose enable is low leaves every register unchanged.
- R8: While reset is asserted, every general register reads zero and both counter halves read zero.
- R9: After reset, the low counter half increases by exactly one each clock and wraps modulo 2^(CNT_W/2) into the upper half.
- R10: A low-half read strobe captures the upper counter half at that clock edge (state SNAP_HELD). Until the next strobe, the upper-half output holds the captured value while the counter keeps running.
- R11: A high-half read strobe in state SNAP_HELD, with no low-half strobe, returns to state SNAP_LIVE. The upper-half output then follows the live counter again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| rd_addr_i | input | 2*NUM_SLOTS*AW | Read addresses; port p at bits [p*AW +: AW], ports 2s and 2s+1 belong to slot s |
| rd_data_o | output | 2*NUM_SLOTS*DATA_W | Read data; port p at bits [p*DATA_W +: DATA_W] |
| wr_en_i | input | NUM_SLOTS | Write enable, one bit per slot |
| wr_addr_i | input | NUM_SLOTS*AW | Write address; slot s at bits [s*AW +: AW] |
| wr_data_i | input | NUM_SLOTS*DATA_W | Write data; slot s at bits [s*DATA_W +: DATA_W] |
| ctr_rd_lo_i | input | 1 | Low-half read strobe; captures the upper half |
| ctr_rd_hi_i | input | 1 | High-half read strobe; releases the capture |
| ctr_lo_o | output | CNT_W/2 | Live low half of the cycle counter |
| ctr_hi_o | output | CNT_W/2 | Upper half: live in SNAP_LIVE, captured in SNAP_HELD |

## Verification
The bench aims at the corner cases that are easy to get wrong. If the slot priority were inverted, a two-slot collision on one register would leave the lower slot's data behind. If the bank forwarded writes internally, a same-cycle read would show the new data instead of the old. If the constant registers were stored like any other register, a write to register 1 would turn it into arbitrary data. The bench builds the counter narrow, so the low half wraps within a few hundred cycles. The capture can therefore be checked across a carry. A design that did not hold the capture would show the incremented upper half right after the wrap, and a design that never released it would stay stale after the high-half strobe.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int DEF_SLOTS  = 5;
    localparam int DEF_REGS   = 128;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_CNT_W  = 64;

    typedef enum logic {
        SNAP_LIVE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
    parameter int NUM_REGS  = vrf_pkg::DEF_REGS,
    parameter int DATA_W    = vrf_pkg::DEF_DATA_W,
    parameter int NUM_SLOTS = vrf_pkg::DEF_SLOTS,
    parameter int AW        = $clog2(NUM_REGS)
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [NUM_SLOTS-1:0]          wr_en_i,
    input  logic [NUM_SLOTS*AW-1:0]       wr_addr_i,
    input  logic [NUM_SLOTS*DATA_W-1:0]   wr_data_i,
    output logic [NUM_REGS*DATA_W-1:0]    flat_o
);
    // Only registers 2 and up hold state; 0 and 1 are constants.
    logic [DATA_W-1:0] cells [2:NUM_REGS-1];
    logic [DATA_W-1:0] nxt   [2:NUM_REGS-1];

    // Later slots overwrite earlier ones, so the highest index wins.
    always_comb begin
        for (int r = 2; r < NUM_REGS; r++) begin
            nxt[r] = cells[r];
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_en_i[s] && (wr_addr_i[s*AW +: AW] == AW'(r))) begin
                    nxt[r] = wr_data_i[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            for (int r = 2; r < NUM_REGS; r++) cells[r] <= '0;
        end else begin
            for (int r = 2; r < NUM_REGS; r++) cells[r] <= nxt[r];
        end
    end

    assign flat_o[0 +: DATA_W]      = '0;
    assign flat_o[DATA_W +: DATA_W] = DATA_W'(1);
    for (genvar g = 2; g < NUM_REGS; g++) begin : g_flat
        assign flat_o[g*DATA_W +: DATA_W] = cells[g];
    end
endmodule

// File: rtl/vrf_read_mux.sv
module vrf_read_mux #(
    parameter int NUM_REGS = vrf_pkg::DEF_REGS,
    parameter int DATA_W   = vrf_pkg::DEF_DATA_W,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] flat_i,
    input  logic [AW-1:0]              addr_i,
    output logic [DATA_W-1:0]          data_o
);
    assign data_o = flat_i[addr_i*DATA_W +: DATA_W];
endmodule

// File: rtl/vrf_cycle_ctr.sv
module vrf_cycle_ctr
    import vrf_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o,
    output snap_state_e       state_o
);
    logic [CNT_W-1:0]  count;
    logic [HALF_W-1:0] hi_snap;
    snap_state_e       state, state_nxt;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) count <= '0;
        else       count <= count + 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)        hi_snap <= '0;
        else if (rd_lo_i) hi_snap <= count[CNT_W-1:HALF_W];
    end

    // State register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state <= SNAP_LIVE;
        else       state <= state_nxt;
    end

    // Transitions: LIVE_TO_HELD, HELD_RECAPTURE, HELD_TO_LIVE
    always_comb begin
        state_nxt = state;
        unique case (state)
            SNAP_LIVE: if (rd_lo_i) state_nxt = SNAP_HELD;
            SNAP_HELD: begin
                if (rd_lo_i)      state_nxt = SNAP_HELD;
                else if (rd_hi_i) state_nxt = SNAP_LIVE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        lo_o = count[HALF_W-1:0];
        hi_o = count[CNT_W-1:HALF_W];
        unique case (state)
            SNAP_LIVE: hi_o = count[CNT_W-1:HALF_W];
            SNAP_HELD: hi_o = hi_snap;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/vrf_top.sv
module vrf_top
    import vrf_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int NUM_REGS  = DEF_REGS,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int AW        = $clog2(NUM_REGS),
    parameter int NRD       = 2 * NUM_SLOTS,
    parameter int HALF_W    = CNT_W / 2
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [NRD*AW-1:0]           rd_addr_i,
    output logic [NRD*DATA_W-1:0]       rd_data_o,
    input  logic [NUM_SLOTS-1:0]        wr_en_i,
    input  logic [NUM_SLOTS*AW-1:0]     wr_addr_i,
    input  logic [NUM_SLOTS*DATA_W-1:0] wr_data_i,
    input  logic                        ctr_rd_lo_i,
    input  logic                        ctr_rd_hi_i,
    output logic [HALF_W-1:0]           ctr_lo_o,
    output logic [HALF_W-1:0]           ctr_hi_o
);
    logic [NUM_REGS*DATA_W-1:0] bank_flat;
    snap_state_e                snap_state;

    vrf_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .AW(AW)
    ) i_bank (
        .clk_i(clk_i), .rst_i(rst_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .flat_o(bank_flat)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        vrf_read_mux #(
            .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)
        ) i_mux (
            .flat_i(bank_flat),
            .addr_i(rd_addr_i[p*AW +: AW]),
            .data_o(rd_data_o[p*DATA_W +: DATA_W])
        );
    end

    vrf_cycle_ctr #(.CNT_W(CNT_W), .HALF_W(HALF_W)) i_ctr (
        .clk_i(clk_i), .rst_i(rst_i),
        .rd_lo_i(ctr_rd_lo_i), .rd_hi_i(ctr_rd_hi_i),
        .lo_o(ctr_lo_o), .hi_o(ctr_hi_o), .state_o(snap_state)
    );
endmodule

// File: rtl/vrf_sva.sv
module vrf_sva
    import vrf_pkg::*;
#(
    parameter int NRD    = 10,
    parameter int AW     = 7,
    parameter int DATA_W = 32,
    parameter int HALF_W = 32
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic [NRD*AW-1:0]     rd_addr_i,
    input logic [NRD*DATA_W-1:0] rd_data_o,
    input logic                  ctr_rd_lo_i,
    input logic                  ctr_rd_hi_i,
    input logic [HALF_W-1:0]     ctr_lo_o,
    input logic [HALF_W-1:0]     ctr_hi_o,
    input snap_state_e           snap_state
);
    for (genvar p = 0; p < NRD; p++) begin : g_port
        a_r2_zero_reg: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_addr_i[p*AW +: AW] == '0) |-> (rd_data_o[p*DATA_W +: DATA_W] == '0));
        a_r3_one_reg: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_addr_i[p*AW +: AW] == AW'(1)) |-> (rd_data_o[p*DATA_W +: DATA_W] == DATA_W'(1)));
    end

    a_r9_ctr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (ctr_lo_o == $past(ctr_lo_o) + 1'b1));

    a_r10_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        ctr_rd_lo_i |=> (snap_state == SNAP_HELD));

    a_r10_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (snap_state == SNAP_HELD && !ctr_rd_lo_i && !ctr_rd_hi_i) |=> $stable(ctr_hi_o));

    a_r11_release: assert property (@(posedge clk_i) disable iff (rst_i)
        (snap_state == SNAP_HELD && ctr_rd_hi_i && !ctr_rd_lo_i) |=> (snap_state == SNAP_LIVE));
endmodule

bind vrf_top vrf_sva #(
    .NRD(NRD), .AW(AW), .DATA_W(DATA_W), .HALF_W(HALF_W)
) i_vrf_sva (
    .clk_i(clk_i), .rst_i(rst_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ctr_rd_lo_i(ctr_rd_lo_i), .ctr_rd_hi_i(ctr_rd_hi_i),
    .ctr_lo_o(ctr_lo_o), .ctr_hi_o(ctr_hi_o),
    .snap_state(snap_state)
);

// File: tb/test_vrf_top.sv
module test_vrf_top;
    localparam int NS = 5;
    localparam int NR = 128;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int AW = 7;
    localparam int NP = 2 * NS;
    localparam int HW = CW / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP*AW-1:0] rd_addr = '0;
    logic [NP*DW-1:0] rd_data;
    logic [NS-1:0]    wr_en = '0;
    logic [NS*AW-1:0] wr_addr = '0;
    logic [NS*DW-1:0] wr_data = '0;
    logic rd_lo = 1'b0, rd_hi = 1'b0;
    logic [HW-1:0] lo, hi;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] model [NR];

    always #5 clk = ~clk;

    vrf_top #(.NUM_SLOTS(NS), .NUM_REGS(NR), .DATA_W(DW), .CNT_W(CW)) i_vrf_top (
        .clk_i(clk), .rst_i(rst),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ctr_rd_lo_i(rd_lo), .ctr_rd_hi_i(rd_hi),
        .ctr_lo_o(lo), .ctr_hi_o(hi)
    );

    // slot, address, data
    localparam logic [41:0] VECS [0:7] = '{
        {3'd0, 7'd5,   32'hDEAD_BEEF},
        {3'd1, 7'd127, 32'h1234_5678},
        {3'd2, 7'd2,   32'hCAFE_F00D},
        {3'd3, 7'd0,   32'hFFFF_FFFF},
        {3'd4, 7'd1,   32'hA5A5_A5A5},
        {3'd4, 7'd64,  32'h0000_0001},
        {3'd2, 7'd5,   32'h0BAD_C0DE},
        {3'd3, 7'd99,  32'h8000_0000}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] port_data(input int p);
        return rd_data[p*DW +: DW];
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [HW-1:0] h0, l0;
        for (int i = 0; i < NR; i++) model[i] = (i == 1) ? 32'd1 : 32'd0;

        // R8: reset state
        repeat (3) @(negedge clk);
        rd_addr[0 +: AW] = 7'd7;
        #1;
        check("R8 reg during reset", port_data(0), 32'd0);
        check("R8 ctr lo during reset", {24'd0, lo}, 32'd0);
        check("R8 ctr hi during reset", {24'd0, hi}, 32'd0);
        rst = 1'b0;

        // Table: write through one slot, read old value same cycle, then new
        for (int v = 0; v < 8; v++) begin
            int s;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            s = int'(VECS[v][41:39]);
            a = VECS[v][38:32];
            d = VECS[v][31:0];
            @(negedge clk);
            wr_en = '0;
            wr_en[s] = 1'b1;
            wr_addr[s*AW +: AW] = a;
            wr_data[s*DW +: DW] = d;
            rd_addr[0 +: AW] = a;
            rd_addr[(2*s+1)*AW +: AW] = a;
            #1;
            check("R6 old value on same-cycle read", port_data(0), model[a]);
            @(negedge clk);
            wr_en = '0;
            if (a >= 2) model[a] = d;
            #1;
            if (a >= 2) check("R1 write then read", port_data(2*s+1), model[a]);
            else        check("R4 constant reg ignores write", port_data(2*s+1), model[a]);
        end

        // R5: two slot collisions in one cycle
        @(negedge clk);
        wr_en = 5'b10110;
        wr_addr[1*AW +: AW] = 7'd20; wr_data[1*DW +: DW] = 32'h1111_1111;
        wr_addr[4*AW +: AW] = 7'd20; wr_data[4*DW +: DW] = 32'h4444_4444;
        wr_addr[2*AW +: AW] = 7'd21; wr_data[2*DW +: DW] = 32'h2222_2222;
        @(negedge clk);
        wr_en = 5'b00001;
        wr_addr[0 +: AW] = 7'd21; wr_data[0 +: DW] = 32'h0000_0000;
        wr_en[3] = 1'b1;
        wr_addr[3*AW +: AW] = 7'd21; wr_data[3*DW +: DW] = 32'h3333_3333;
        rd_addr[3*AW +: AW] = 7'd20;
        #1;
        check("R5 highest slot wins (4 over 1)", port_data(3), 32'h4444_4444);
        @(negedge clk);
        wr_en = '0;
        rd_addr[4*AW +: AW] = 7'd21;
        #1;
        check("R5 highest slot wins (3 over 0)", port_data(4), 32'h3333_3333);

        // R7: disabled write ports change nothing
        @(negedge clk);
        wr_en = '0;
        for (int s = 0; s < NS; s++) begin
            wr_addr[s*AW +: AW] = 7'd20;
            wr_data[s*DW +: DW] = 32'h7777_7777;
        end
        @(negedge clk);
        #1;
        check("R7 disabled write", port_data(3), 32'h4444_4444);

        // R2/R3: constants on every port
        for (int p = 0; p < NP; p++) rd_addr[p*AW +: AW] = 7'd0;
        #1;
        for (int p = 0; p < NP; p++) check("R2 reg0 reads zero", port_data(p), 32'd0);
        for (int p = 0; p < NP; p++) rd_addr[p*AW +: AW] = 7'd1;
        #1;
        for (int p = 0; p < NP; p++) check("R3 reg1 reads one", port_data(p), 32'd1);

        // R9: counter step
        @(negedge clk);
        l0 = lo;
        @(negedge clk);
        check("R9 counter step", {24'd0, lo}, {24'd0, HW'(l0 + 1'b1)});

        // R10: capture across a carry
        for (int i = 0; i < 300 && lo != 8'hFF; i++) @(negedge clk);
        h0 = hi;
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        #1;
        check("R9 low half wraps", {24'd0, lo}, 32'd0);
        check("R10 high half held across carry", {24'd0, hi}, {24'd0, h0});
        repeat (3) @(negedge clk);
        #1;
        check("R10 high half still held", {24'd0, hi}, {24'd0, h0});

        // R11: release back to live
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        #1;
        check("R11 high half live again", {24'd0, hi}, {24'd0, HW'(h0 + 1'b1)});

        finish_run();
    end
endmodule